// File: doc/BRIEF.md
# Variable-Page Address Translator with Instruction Micro-Cache

This block turns 32-bit virtual addresses into physical addresses. Translations live in a main table of 64 entries. The table is fully associative: every lookup compares against all valid entries at once. Each entry is one 64-bit word. It holds a virtual page number, a physical page number, a page-size code and a valid bit. The page size is set per entry and may be one of six powers of four, from 4 KB to 4 MB. Address bits below the entry's page size are left out of the compare and pass straight through into the physical address.

Data accesses always look up the main table. Instruction fetches first check a two-entry micro-cache of recent translations. Only when that check misses does the fetch go to the main table. On a main-table hit, the micro-cache is refilled in one extra cycle, and the refill replaces the least recently used of its two slots. When a data access and a pending instruction lookup both need the main table in the same cycle, the data access goes first. Any write to the main table empties the micro-cache. Each response also reports which half of the address space the address falls in: the lower 2 GB is the user half and the upper 2 GB is the kernel half.

Top module: `vpt_xlat`

## Requirements
- R1: After reset, every main entry and both micro entries are invalid, `i_ready` is 1, and neither response valid is asserted. Any lookup then misses.
- R2: A data request in cycle t gives `d_rsp_valid`, together with exactly one of `d_hit` / `d_miss` and the value of `d_pa`, at the next clock edge.
- R3: Size code s (0=4K, 1=16K, 2=64K, 3=256K, 4=1M, 5=4M) makes the low 12+2s address bits an offset. The offset is ignored in the compare and copied into the physical address. The bits above the offset come from the entry's physical page number.
- R4: An entry whose size code is 6 or 7, or whose valid bit is 0, never matches.
- R5: When several valid entries match, the translation comes from the one with the lowest index.
- R6: An accepted fetch (`i_req` while `i_ready`) that hits the micro-cache responds at the next edge, and `i_ready` stays 1.
- R7: A fetch that misses the micro-cache drops `i_ready` and looks up the main table. On a main hit it responds three edges after acceptance. On a main miss it responds with `i_miss` two edges after acceptance.
- R8: A refill goes into the least recently used micro slot. A micro hit makes the slot that hit the most recently used.
- R9: Any main-table write invalidates both micro entries.
- R10: When a data request arrives in the same cycle as a pending instruction main-table lookup, the data request is served and the instruction lookup waits one cycle.
- R11: `d_kern` / `i_kern` equal bit 31 of the looked-up virtual address.
- R12: A write stores the entry at `wr_idx`, and lookups from the following cycle on see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_req | input | 1 | Instruction lookup request |
| i_va | input | 32 | Instruction virtual address |
| i_ready | output | 1 | Instruction side can accept a request |
| i_rsp_valid | output | 1 | Instruction response valid |
| i_hit | output | 1 | Instruction translation found |
| i_miss | output | 1 | Instruction translation not found |
| i_pa | output | 32 | Instruction physical address |
| i_kern | output | 1 | Instruction address is in the upper half |
| d_req | input | 1 | Data lookup request |
| d_va | input | 32 | Data virtual address |
| d_rsp_valid | output | 1 | Data response valid |
| d_hit | output | 1 | Data translation found |
| d_miss | output | 1 | Data translation not found |
| d_pa | output | 32 | Data physical address |
| d_kern | output | 1 | Data address is in the upper half |
| wr_en | input | 1 | Write a main-table entry |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number (4 KB units) |
| wr_ppn | input | 20 | Physical page number (4 KB units) |
| wr_size | input | 3 | Page-size code |
| wr_valid | input | 1 | Valid bit of the written entry |

## Verification
The hardest case to reach is a data request landing in the exact cycle when an instruction fetch is waiting on the main table. The bench sets this up by first emptying the micro-cache with a table write. It then issues a fetch and raises `d_req` during the fetch's lookup cycle. This checks the data answer, the one-cycle instruction delay and the later refill. Least-recently-used replacement is reached through a fixed order of fetches: fill, touch, fill again. The bench then shows which slot survived by measuring the latency of a repeat fetch.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int VA_W      = 32;
  localparam int PG_SHIFT  = 12;
  localparam int VPN_W     = VA_W - PG_SHIFT;
  localparam int PPN_W     = VPN_W;
  localparam int PA_W      = PPN_W + PG_SHIFT;
  localparam int SZ_W      = 3;
  localparam int NUM_SIZES = 6;
  localparam int ENT_W     = 64;
  localparam int RSV_W     = ENT_W - 1 - SZ_W - VPN_W - PPN_W;

  typedef struct packed {
    logic             valid;
    logic [SZ_W-1:0]  size;
    logic [RSV_W-1:0] rsv;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } tlb_ent_t;

  // bits of the page number that fall inside the page offset
  function automatic logic [VPN_W-1:0] span_mask(input logic [SZ_W-1:0] s);
    logic [VPN_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SIZES - 1; i++)
      if (int'(s) > i) m[2*i +: 2] = 2'b11;
    return m;
  endfunction

  function automatic logic size_legal(input logic [SZ_W-1:0] s);
    return int'(s) < NUM_SIZES;
  endfunction

  function automatic logic ent_match(input tlb_ent_t e, input logic [VPN_W-1:0] vpn);
    return e.valid && size_legal(e.size) &&
           (((e.vpn ^ vpn) & ~span_mask(e.size)) == '0);
  endfunction

  function automatic logic [PPN_W-1:0] xlate(input tlb_ent_t e, input logic [VPN_W-1:0] vpn);
    logic [VPN_W-1:0] m;
    m = span_mask(e.size);
    return (e.ppn & ~m) | (vpn & m);
  endfunction
endpackage

// File: rtl/vpt_main_tlb.sv
module vpt_main_tlb
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output tlb_ent_t         lk_ent
);
  tlb_ent_t           tbl [ENTRIES];
  logic [ENTRIES-1:0] mvec;
  logic [IDX_W-1:0]   sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_ent;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign mvec[g] = ent_match(tbl[g], lk_vpn);
  end

  // lowest matching index wins
  always_comb begin
    lk_hit = 1'b0;
    sel    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (mvec[i]) begin
        lk_hit = 1'b1;
        sel    = IDX_W'(i);
      end
    end
  end

  assign lk_ent = tbl[sel];

  // R12
  wr_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tbl[$past(wr_idx)] == $past(wr_ent));
endmodule

// File: rtl/vpt_micro_tlb.sv
module vpt_micro_tlb
  import vpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_en,
  output logic             lk_hit,
  output tlb_ent_t         lk_ent,
  input  logic             fill_en,
  input  tlb_ent_t         fill_ent,
  input  logic             flush
);
  localparam int UENT = 2;

  tlb_ent_t        slot [UENT];
  logic [UENT-1:0] mv;
  logic            hidx;
  logic            lru;

  for (genvar g = 0; g < UENT; g++) begin : g_cmp
    assign mv[g] = ent_match(slot[g], lk_vpn);
  end

  assign lk_hit = |mv;
  assign hidx   = ~mv[0];
  assign lk_ent = slot[hidx];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < UENT; i++) slot[i] <= '0;
      lru <= 1'b0;
    end else if (fill_en) begin
      slot[lru] <= fill_ent;
      lru       <= ~lru;
    end else if (lk_en && lk_hit) begin
      lru <= ~hidx;
    end
  end

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !slot[0].valid && !slot[1].valid);

  // R8
  fill_lru_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=> lru != $past(lru));
endmodule

// File: rtl/vpt_xlat.sv
module vpt_xlat
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_req,
  input  logic [VA_W-1:0]  i_va,
  output logic             i_ready,
  output logic             i_rsp_valid,
  output logic             i_hit,
  output logic             i_miss,
  output logic [PA_W-1:0]  i_pa,
  output logic             i_kern,
  input  logic             d_req,
  input  logic [VA_W-1:0]  d_va,
  output logic             d_rsp_valid,
  output logic             d_hit,
  output logic             d_miss,
  output logic [PA_W-1:0]  d_pa,
  output logic             d_kern,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [SZ_W-1:0]  wr_size,
  input  logic             wr_valid
);
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_FILL} ist_e;

  ist_e            st;
  logic [VA_W-1:0] iva_q;
  tlb_ent_t        fill_q;
  logic            stale_q;

  tlb_ent_t         wr_ent;
  logic [VPN_W-1:0] m_vpn;
  logic             m_hit;
  tlb_ent_t         m_ent;
  logic             u_hit;
  tlb_ent_t         u_ent;
  logic             i_acc;
  logic             walk_go;
  logic             fill_en;

  always_comb begin
    wr_ent       = '0;
    wr_ent.valid = wr_valid;
    wr_ent.size  = wr_size;
    wr_ent.vpn   = wr_vpn;
    wr_ent.ppn   = wr_ppn;
  end

  assign i_ready = (st == ST_IDLE);
  assign i_acc   = i_req && i_ready;
  assign walk_go = (st == ST_WALK) && !d_req;
  assign m_vpn   = d_req ? d_va[VA_W-1:PG_SHIFT] : iva_q[VA_W-1:PG_SHIFT];
  assign fill_en = (st == ST_FILL) && !stale_q && !wr_en;

  vpt_main_tlb #(.ENTRIES(ENTRIES)) u_main (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_ent (wr_ent),
    .lk_vpn (m_vpn),
    .lk_hit (m_hit),
    .lk_ent (m_ent)
  );

  vpt_micro_tlb u_micro (
    .clk      (clk),
    .rst      (rst),
    .lk_vpn   (i_va[VA_W-1:PG_SHIFT]),
    .lk_en    (i_acc),
    .lk_hit   (u_hit),
    .lk_ent   (u_ent),
    .fill_en  (fill_en),
    .fill_ent (fill_q),
    .flush    (wr_en)
  );

  // instruction sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      iva_q   <= '0;
      fill_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (i_acc && !u_hit) begin
          st    <= ST_WALK;
          iva_q <= i_va;
        end
        ST_WALK: if (walk_go) begin
          if (m_hit) begin
            st      <= ST_FILL;
            fill_q  <= m_ent;
            stale_q <= wr_en;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // instruction response
  always_ff @(posedge clk) begin
    if (rst) begin
      i_rsp_valid <= 1'b0;
      i_hit       <= 1'b0;
      i_miss      <= 1'b0;
      i_pa        <= '0;
      i_kern      <= 1'b0;
    end else begin
      i_rsp_valid <= 1'b0;
      i_hit       <= 1'b0;
      i_miss      <= 1'b0;
      if (i_acc && u_hit) begin
        i_rsp_valid <= 1'b1;
        i_hit       <= 1'b1;
        i_pa        <= {xlate(u_ent, i_va[VA_W-1:PG_SHIFT]), i_va[PG_SHIFT-1:0]};
        i_kern      <= i_va[VA_W-1];
      end else if (walk_go && !m_hit) begin
        i_rsp_valid <= 1'b1;
        i_miss      <= 1'b1;
        i_pa        <= '0;
        i_kern      <= iva_q[VA_W-1];
      end else if (st == ST_FILL) begin
        i_rsp_valid <= 1'b1;
        i_hit       <= 1'b1;
        i_pa        <= {xlate(fill_q, iva_q[VA_W-1:PG_SHIFT]), iva_q[PG_SHIFT-1:0]};
        i_kern      <= iva_q[VA_W-1];
      end
    end
  end

  // data response
  always_ff @(posedge clk) begin
    if (rst) begin
      d_rsp_valid <= 1'b0;
      d_hit       <= 1'b0;
      d_miss      <= 1'b0;
      d_pa        <= '0;
      d_kern      <= 1'b0;
    end else begin
      d_rsp_valid <= d_req;
      d_hit       <= d_req && m_hit;
      d_miss      <= d_req && !m_hit;
      if (d_req) begin
        d_pa   <= m_hit ? {xlate(m_ent, d_va[VA_W-1:PG_SHIFT]), d_va[PG_SHIFT-1:0]} : '0;
        d_kern <= d_va[VA_W-1];
      end
    end
  end

  // R10
  data_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WALK && d_req) |=> (st == ST_WALK && !i_rsp_valid));

  // R7
  fill_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL) |=> (i_rsp_valid && i_hit && st == ST_IDLE));

  // R2
  d_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    d_req |=> (d_rsp_valid && (d_hit != d_miss)));

  // R6
  i_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (i_req && i_ready) |=> (i_rsp_valid || !i_ready));
endmodule

// File: tb/vpt_xlat_tb.sv
`timescale 1ns/1ps
module vpt_xlat_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        i_req = 1'b0, d_req = 1'b0, wr_en = 1'b0, wr_valid = 1'b0;
  logic [31:0] i_va = '0, d_va = '0;
  logic        i_ready, i_rsp_valid, i_hit, i_miss, i_kern;
  logic        d_rsp_valid, d_hit, d_miss, d_kern;
  logic [31:0] i_pa, d_pa;
  logic [5:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0, wr_ppn = '0;
  logic [2:0]  wr_size = '0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  vpt_xlat u_dut (
    .clk(clk), .rst(rst),
    .i_req(i_req), .i_va(i_va), .i_ready(i_ready), .i_rsp_valid(i_rsp_valid),
    .i_hit(i_hit), .i_miss(i_miss), .i_pa(i_pa), .i_kern(i_kern),
    .d_req(d_req), .d_va(d_va), .d_rsp_valid(d_rsp_valid), .d_hit(d_hit),
    .d_miss(d_miss), .d_pa(d_pa), .d_kern(d_kern),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .wr_size(wr_size), .wr_valid(wr_valid)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] epa(input logic [19:0] ppn, input logic [2:0] sz,
                                      input logic [31:0] va);
    logic [31:0] m;
    m = (32'd1 << (12 + 2 * int'(sz))) - 32'd1;
    return ({ppn, 12'h000} & ~m) | (va & m);
  endfunction

  task automatic wr(input logic [5:0] idx, input logic [19:0] vpn, input logic [19:0] ppn,
                    input logic [2:0] sz, input logic v);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_ppn = ppn; wr_size = sz; wr_valid = v;
    tick;
    wr_en = 1'b0;
  endtask

  task automatic dlook(input string rq, input logic [31:0] va, input logic eh,
                       input logic [31:0] ep);
    d_req = 1'b1; d_va = va;
    tick;
    d_req = 1'b0;
    check({rq, " d_rsp_valid"}, 32'(d_rsp_valid), 32'd1);
    check({rq, " d_hit"}, 32'(d_hit), 32'(eh));
    check({rq, " d_miss"}, 32'(d_miss), 32'(!eh));
    if (eh) check({rq, " d_pa"}, d_pa, ep);
    check("R11 d_kern", 32'(d_kern), 32'(va[31]));
  endtask

  task automatic ifetch(input string rq, input logic [31:0] va, input logic eh,
                        input logic [31:0] ep, input int elat);
    int lat;
    check({rq, " i_ready before"}, 32'(i_ready), 32'd1);
    i_req = 1'b1; i_va = va;
    tick;
    i_req = 1'b0;
    lat = 1;
    if (elat > 1) check("R7 i_ready low while walking", 32'(i_ready), 32'd0);
    while (!i_rsp_valid && lat < 10) begin
      tick;
      lat++;
    end
    check({rq, " latency"}, 32'(lat), 32'(elat));
    check({rq, " i_hit"}, 32'(i_hit), 32'(eh));
    check({rq, " i_miss"}, 32'(i_miss), 32'(!eh));
    if (eh) check({rq, " i_pa"}, i_pa, ep);
    check("R11 i_kern", 32'(i_kern), 32'(va[31]));
  endtask

  task automatic t_reset;
    check("R1 i_ready", 32'(i_ready), 32'd1);
    check("R1 i_rsp_valid", 32'(i_rsp_valid), 32'd0);
    check("R1 d_rsp_valid", 32'(d_rsp_valid), 32'd0);
    dlook("R1 empty data", 32'h0001_0000, 1'b0, 32'h0);
    ifetch("R1 empty fetch", 32'h0001_0000, 1'b0, 32'h0, 2);
  endtask

  task automatic t_fill_table;
    wr(6'd5,  20'h00010, 20'hABCDE, 3'd0, 1'b1);
    wr(6'd6,  20'h80400, 20'h12300, 3'd5, 1'b1);
    wr(6'd7,  20'h00200, 20'h55550, 3'd2, 1'b1);
    wr(6'd8,  20'h01000, 20'h0AB00, 3'd4, 1'b1);
    wr(6'd9,  20'h02040, 20'h33340, 3'd3, 1'b1);
    wr(6'd10, 20'h00300, 20'h77777, 3'd6, 1'b1);
    wr(6'd11, 20'h00600, 20'h66666, 3'd7, 1'b1);
    wr(6'd30, 20'h00500, 20'h44444, 3'd0, 1'b0);
    wr(6'd20, 20'h00400, 20'h11111, 3'd0, 1'b1);
    wr(6'd3,  20'h00400, 20'h22220, 3'd1, 1'b1);
  endtask

  task automatic t_sizes;
    dlook("R3 4K", 32'h0001_0ABC, 1'b1, epa(20'hABCDE, 3'd0, 32'h0001_0ABC));
    dlook("R3 4K outside", 32'h0001_1000, 1'b0, 32'h0);
    dlook("R3 16K", 32'h0040_3FF0, 1'b1, epa(20'h22220, 3'd1, 32'h0040_3FF0));
    dlook("R3 64K", 32'h0020_ABCD, 1'b1, epa(20'h55550, 3'd2, 32'h0020_ABCD));
    dlook("R3 64K outside", 32'h0021_0000, 1'b0, 32'h0);
    dlook("R3 256K", 32'h0207_FFFC, 1'b1, epa(20'h33340, 3'd3, 32'h0207_FFFC));
    dlook("R3 1M", 32'h010F_0F0F, 1'b1, epa(20'h0AB00, 3'd4, 32'h010F_0F0F));
    dlook("R3 4M kernel", 32'h805F_1234, 1'b1, epa(20'h12300, 3'd5, 32'h805F_1234));
  endtask

  task automatic t_invalid;
    dlook("R4 size code 6", 32'h0030_0000, 1'b0, 32'h0);
    dlook("R4 size code 7", 32'h0060_0000, 1'b0, 32'h0);
    dlook("R4 valid clear", 32'h0050_0000, 1'b0, 32'h0);
  endtask

  task automatic t_priority;
    // R5: entries 3 and 20 both cover 0x00400010; index 3 must win
    dlook("R5 lowest index", 32'h0040_0010, 1'b1, epa(20'h22220, 3'd1, 32'h0040_0010));
    // R12: overwrite entry 3 so entry 20 becomes the only match
    wr(6'd3, 20'h00400, 20'h22220, 3'd1, 1'b0);
    dlook("R12 overwrite", 32'h0040_0010, 1'b1, epa(20'h11111, 3'd0, 32'h0040_0010));
  endtask

  task automatic t_micro_lru;
    ifetch("R7 refill A", 32'h0001_0ABC, 1'b1, epa(20'hABCDE, 3'd0, 32'h0001_0ABC), 3);
    ifetch("R6 hit A", 32'h0001_0FFC, 1'b1, epa(20'hABCDE, 3'd0, 32'h0001_0FFC), 1);
    ifetch("R7 refill B", 32'h0020_1000, 1'b1, epa(20'h55550, 3'd2, 32'h0020_1000), 3);
    ifetch("R6 hit A again", 32'h0001_0000, 1'b1, epa(20'hABCDE, 3'd0, 32'h0001_0000), 1);
    ifetch("R8 refill C evicts B", 32'h805F_1234, 1'b1, epa(20'h12300, 3'd5, 32'h805F_1234), 3);
    ifetch("R8 A kept", 32'h0001_0004, 1'b1, epa(20'hABCDE, 3'd0, 32'h0001_0004), 1);
    ifetch("R8 B evicted", 32'h0020_0000, 1'b1, epa(20'h55550, 3'd2, 32'h0020_0000), 3);
    ifetch("R7 main miss", 32'h0030_0000, 1'b0, 32'h0, 2);
  endtask

  task automatic t_flush;
    ifetch("R9 before write", 32'h0001_0010, 1'b1, epa(20'hABCDE, 3'd0, 32'h0001_0010), 1);
    wr(6'd40, 20'h0FFF0, 20'h01234, 3'd0, 1'b1);
    ifetch("R9 after write", 32'h0001_0010, 1'b1, epa(20'hABCDE, 3'd0, 32'h0001_0010), 3);
  endtask

  task automatic t_conflict;
    check("R10 i_ready before", 32'(i_ready), 32'd1);
    i_req = 1'b1; i_va = 32'h010F_0F0F;
    tick;
    i_req = 1'b0;
    d_req = 1'b1; d_va = 32'h0207_FFFC;
    tick;
    d_req = 1'b0;
    check("R10 data served", 32'(d_hit), 32'd1);
    check("R10 data pa", d_pa, epa(20'h33340, 3'd3, 32'h0207_FFFC));
    check("R10 fetch held", 32'(i_rsp_valid), 32'd0);
    check("R10 still busy", 32'(i_ready), 32'd0);
    tick;
    check("R10 fetch in refill", 32'(i_rsp_valid), 32'd0);
    tick;
    check("R10 fetch done", 32'(i_rsp_valid), 32'd1);
    check("R10 fetch hit", 32'(i_hit), 32'd1);
    check("R10 fetch pa", i_pa, epa(20'h0AB00, 3'd4, 32'h010F_0F0F));
    ifetch("R10 refilled", 32'h0100_0000, 1'b1, epa(20'h0AB00, 3'd4, 32'h0100_0000), 1);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_fill_table;
    t_sizes;
    t_invalid;
    t_priority;
    t_micro_lru;
    t_flush;
    t_conflict;
    finish_up;
  end
endmodule